// File: doc/BRIEF.md
# Sequential Double-Width Unsigned Divider

This block divides an unsigned dividend of twice the word width by a one-word divisor. It returns a one-word quotient and a one-word remainder from a single operation. The dividend is built from two operands: `hi` is the upper word and `lo` is the lower word. The divisor is zero-extended to the full dividend width before dividing. An operation is launched with a one-cycle `start` and finishes with a one-cycle `done`. After `done`, the results stay on `quotient` and `remainder` until the next accepted launch.

A valid division needs two conditions: `hi` is strictly below the divisor, and the divisor is not zero. Under these conditions the quotient always fits in one word. The datapath is a restoring radix-2 loop that takes one quotient bit per clock. If a condition fails, the block does not iterate. It returns fixed values instead: the quotient is all ones and the remainder is zero.

Because the remainder is always below the divisor, it can be fed back as `hi` for the next lower word. Repeating this word by word divides a multi-word number by a single word.

Top module: `divmod_unit`

## Requirements
- R1: For a valid operation (`hi` < `divisor` and `divisor` != 0, unsigned), `quotient` equals the low WORD_W bits of ({hi,lo}) / divisor, with `hi` in the upper WORD_W bits of the dividend.
- R2: For a valid operation, `remainder` equals ({hi,lo}) mod divisor, which is always below `divisor`.
- R3: When `divisor` is zero or `hi` >= `divisor`, the operation returns `quotient` with every bit 1 and `remainder` with every bit 0.
- R4: For a failing operation, `done` is high in the cycle directly after the clock edge that samples `start`.
- R5: For a valid operation, `done` is high WORD_W+1 cycles after the edge that samples `start`.
- R6: `done` is high for exactly one cycle per operation.
- R7: After `done`, `quotient` and `remainder` keep their values until the next accepted `start`.
- R8: A `start` raised while an operation is in progress is ignored. The running operation completes with its original operands and its original timing.
- R9: After reset, `done` is low and both `quotient` and `remainder` read zero.
- R10: Feeding each `remainder` back as the next `hi`, with the next lower word as `lo`, yields the quotient words and final remainder of a multi-word division by one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request; sampled only when idle |
| hi | input | WORD_W | Upper word of the dividend |
| lo | input | WORD_W | Lower word of the dividend |
| divisor | input | WORD_W | Divisor word |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WORD_W | Quotient, or all ones on error |
| remainder | output | WORD_W | Remainder, or zero on error |

## Verification
A 4-bit instance is swept over every combination of `hi`, `lo` and `divisor`. This covers every valid operand, every case with `hi` equal to or above the divisor, and every zero divisor. It tells apart a wrong quotient bit, a missed or wrong restore step, a wrong error condition, and the two completion latencies.

A 64-bit instance then runs a set of targeted operands:
- the largest legal `hi` with an all-ones divisor and `lo`;
- a divisor of one;
- `hi` equal to the divisor;
- pseudo-random operands.

These expose faults that show up only across the full word width. Further runs on the wide instance check three behaviours: a launch in the middle of an operation, holding of results after `done`, and a two-word chained division that compares the joined quotient against a double-width reference.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRun;   // latch operands for a valid divide
    logic loadErr;   // load saturated error constants
    logic step;      // one restoring iteration
  } dmCtrl_t;
endpackage

// File: rtl/divmod_ctrl.sv
module divmod_ctrl
  import divmod_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] divisor,
  output dmCtrl_t           ctrlOut,
  output logic              done
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  typedef enum logic {ST_IDLE, ST_RUN} dmState_e;

  dmState_e   state;
  logic [CNT_W-1:0] iterCnt;
  logic       badOperands;
  logic       accept;

  always_comb begin
    badOperands     = (divisor == '0) || (hi >= divisor);
    accept          = (state == ST_IDLE) && start;
    ctrlOut.loadRun = accept && !badOperands;
    ctrlOut.loadErr = accept && badOperands;
    ctrlOut.step    = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctrlOut.loadRun) begin
            state   <= ST_RUN;
            iterCnt <= CNT_W'(WORD_W);
          end
          if (ctrlOut.loadErr) done <= 1'b1;
        end
        default: begin
          iterCnt <= iterCnt - 1'b1;
          if (iterCnt == CNT_W'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlOut.loadErr |=> done); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrlOut.loadErr) |=> !done); // R6

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && iterCnt > CNT_W'(1)) |=>
      (state == ST_RUN && iterCnt == $past(iterCnt) - CNT_W'(1))); // R8

  AST_RUN_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlOut.loadRun |=> !done); // R5
endmodule

// File: rtl/divmod_datapath.sv
module divmod_datapath
  import divmod_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmCtrl_t           ctrlIn,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] divisor,
  output logic [WORD_W-1:0] quotient,
  output logic [WORD_W-1:0] remainder
);
  localparam int PART_W = WORD_W + 1;

  logic [WORD_W-1:0] remReg;   // partial remainder, always below divReg
  logic [WORD_W-1:0] shReg;    // low dividend bits out, quotient bits in
  logic [WORD_W-1:0] divReg;
  logic [PART_W-1:0] trial;
  logic [PART_W-1:0] diff;
  logic              fits;

  always_comb begin
    trial = {remReg, shReg[WORD_W-1]};
    diff  = trial - {1'b0, divReg};
    fits  = trial >= {1'b0, divReg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remReg <= '0;
      shReg  <= '0;
      divReg <= '0;
    end else if (ctrlIn.loadRun) begin
      remReg <= hi;
      shReg  <= lo;
      divReg <= divisor;
    end else if (ctrlIn.loadErr) begin
      remReg <= '0;
      shReg  <= '1;
    end else if (ctrlIn.step) begin
      remReg <= fits ? diff[WORD_W-1:0] : trial[WORD_W-1:0];
      shReg  <= {shReg[WORD_W-2:0], fits};
    end
  end

  assign quotient  = shReg;
  assign remainder = remReg;

  AST_PARTIAL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.loadRun || ctrlIn.step) |=> (remReg < divReg)); // R2

  AST_ERR_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlIn.loadErr |=> (quotient == '1 && remainder == '0)); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrlIn.loadRun || ctrlIn.loadErr || ctrlIn.step) |=>
      ($stable(quotient) && $stable(remainder))); // R7
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] divisor,
  output logic              done,
  output logic [WORD_W-1:0] quotient,
  output logic [WORD_W-1:0] remainder
);
  dmCtrl_t ctrlBus;

  divmod_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hi(hi), .divisor(divisor),
    .ctrlOut(ctrlBus), .done(done)
  );

  divmod_datapath #(.WORD_W(WORD_W)) uPath (
    .clk(clk), .rst_n(rst_n), .ctrlIn(ctrlBus), .hi(hi), .lo(lo),
    .divisor(divisor), .quotient(quotient), .remainder(remainder)
  );

  AST_RESET_DONE: assert property (@(posedge clk)
    $rose(rst_n) |-> !done); // R9
endmodule

// File: tb/tb_divmod_unit.sv
module tb_divmod_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // small exhaustive instance
  logic       sStart = 1'b0;
  logic [3:0] sHi = '0, sLo = '0, sDiv = '0;
  logic       sDone;
  logic [3:0] sQuo, sRem;
  // full-width instance
  logic        wStart = 1'b0;
  logic [63:0] wHi = '0, wLo = '0, wDiv = '0;
  logic        wDone;
  logic [63:0] wQuo, wRem;

  int checks = 0;
  int failures = 0;

  divmod_unit #(.WORD_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(sStart), .hi(sHi), .lo(sLo),
    .divisor(sDiv), .done(sDone), .quotient(sQuo), .remainder(sRem)
  );

  divmod_unit #(.WORD_W(64)) dutWide (
    .clk(clk), .rst_n(rst_n), .start(wStart), .hi(wHi), .lo(wLo),
    .divisor(wDiv), .done(wDone), .quotient(wQuo), .remainder(wRem)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectOp(input bit wide, input logic [63:0] h, l, d,
                          output logic [63:0] eq, er, output int elat,
                          output bit err);
    logic [127:0] dv;
    logic [63:0] hh, ll, dd;
    hh = wide ? h : {60'b0, h[3:0]};
    ll = wide ? l : {60'b0, l[3:0]};
    dd = wide ? d : {60'b0, d[3:0]};
    err = (dd == 0) || (hh >= dd);
    dv  = wide ? {hh, ll} : {120'b0, hh[3:0], ll[3:0]};
    if (err) begin
      eq = wide ? '1 : 64'hF;
      er = '0;
      elat = 1;
    end else begin
      eq = 64'(dv / {64'b0, dd});
      er = 64'(dv % {64'b0, dd});
      elat = wide ? 65 : 5;
    end
  endtask

  task automatic runOp(input bit wide, input logic [63:0] h, l, d,
                       output logic [63:0] q, r, output int lat);
    if (wide) begin
      wHi = h; wLo = l; wDiv = d; wStart = 1'b1;
    end else begin
      sHi = h[3:0]; sLo = l[3:0]; sDiv = d[3:0]; sStart = 1'b1;
    end
    @(negedge clk);
    wStart = 1'b0; sStart = 1'b0;
    lat = 1;
    while (!(wide ? wDone : sDone) && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    q = wide ? wQuo : {60'b0, sQuo};
    r = wide ? wRem : {60'b0, sRem};
  endtask

  task automatic checkOp(input bit wide, input logic [63:0] h, l, d);
    logic [63:0] q, r, eq, er;
    int lat, elat;
    bit err;
    expectOp(wide, h, l, d, eq, er, elat, err);
    runOp(wide, h, l, d, q, r, lat);
    if (err) begin
      check(q == eq, "R3 quotient", 128'(q), 128'(eq));
      check(r == er, "R3 remainder", 128'(r), 128'(er));
      check(lat == elat, "R4 latency", 128'(lat), 128'(elat));
    end else begin
      check(q == eq, "R1 quotient", 128'(q), 128'(eq));
      check(r == er, "R2 remainder", 128'(r), 128'(er));
      check(lat == elat, "R5 latency", 128'(lat), 128'(elat));
    end
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] q, r, q1, r1, q2, r2, eq, er, seed, dd;
    logic [127:0] big;
    int lat, elat;
    bit err;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!sDone && !wDone, "R9 done after reset", 128'({sDone, wDone}), 128'(0));
    check(sQuo == 0 && sRem == 0, "R9 small outputs", 128'({sQuo, sRem}), 128'(0));
    check(wQuo == 0 && wRem == 0, "R9 wide outputs", {wQuo, wRem}, 128'(0));

    // exhaustive sweep of the 4-bit instance
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        for (int d = 0; d < 16; d++)
          checkOp(1'b0, 64'(h), 64'(l), 64'(d));

    // full-width directed operands
    checkOp(1'b1, 64'd0, 64'd100, 64'd7);
    checkOp(1'b1, 64'hFFFF_FFFF_FFFF_FFFE, '1, '1);
    checkOp(1'b1, 64'd0, 64'hDEAD_BEEF_0123_4567, 64'd1);
    checkOp(1'b1, 64'd5, 64'd9, 64'd5);
    checkOp(1'b1, 64'd5, 64'd9, 64'd0);
    checkOp(1'b1, 64'd0, 64'd0, 64'd0);
    checkOp(1'b1, 64'h7FFF_FFFF_FFFF_FFFF, '1, 64'h8000_0000_0000_0000);
    seed = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 16; i++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      dd = seed ^ (seed >> (i * 3));
      if (dd == 0) dd = 64'd3;
      checkOp(1'b1, seed % dd, seed * 64'd31, dd);
    end

    // R6 and R7: single pulse, then results held
    expectOp(1'b1, 64'd3, 64'd1000, 64'd11, eq, er, elat, err);
    runOp(1'b1, 64'd3, 64'd1000, 64'd11, q, r, lat);
    @(negedge clk);
    check(!wDone, "R6 done pulse one cycle", 128'(wDone), 128'(0));
    wHi = '1; wLo = '0; wDiv = 64'd2;
    repeat (3) @(negedge clk);
    check(wQuo == eq, "R7 quotient held", 128'(wQuo), 128'(eq));
    check(wRem == er, "R7 remainder held", 128'(wRem), 128'(er));

    // R8: start during a running operation is ignored
    expectOp(1'b1, 64'd9, 64'd77777, 64'd13, eq, er, elat, err);
    wHi = 64'd9; wLo = 64'd77777; wDiv = 64'd13; wStart = 1'b1;
    @(negedge clk);
    wStart = 1'b0;
    repeat (9) @(negedge clk);
    wHi = 64'd1; wLo = 64'd2; wDiv = 64'd0; wStart = 1'b1;
    @(negedge clk);
    wStart = 1'b0;
    wHi = 64'd9; wLo = 64'd77777; wDiv = 64'd13;
    lat = 11;
    check(!wDone, "R8 no early done", 128'(wDone), 128'(0));
    while (!wDone && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 65, "R8 latency unchanged", 128'(lat), 128'(65));
    check(wQuo == eq && wRem == er, "R8 original result", {wQuo, wRem}, {eq, er});

    // R10: two-word chained division
    big = {64'hCAFE_F00D_1234_5678, 64'h0BAD_C0DE_8765_4321};
    dd  = 64'h0000_0001_0000_0007;
    runOp(1'b1, 64'd0, big[127:64], dd, q1, r1, lat);
    runOp(1'b1, r1, big[63:0], dd, q2, r2, lat);
    check({q1, q2} == big / {64'b0, dd}, "R10 chained quotient", {q1, q2},
          big / {64'b0, dd});
    check(128'(r2) == big % {64'b0, dd}, "R10 chained remainder", 128'(r2),
          big % {64'b0, dd});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule